// File: doc/BRIEF.md
# Byte-lane SRAM interface controller

This block sits between a 32-bit processor request port and an on-chip memory built from four 8-bit-wide synchronous SRAM banks that together hold one 32-bit word. A request names an address, a transfer size (byte, halfword, longword or a 128-bit line), a direction and write data. The controller turns it into bank cycles. It asserts an active-low chip select, presents a word address and replicated write data, and then raises a strobe for each bank that takes part. One cycle later it returns the read data, aligned to the low bits, together with an acknowledge.

A static 3-bit size code gives the array capacity. Codes 1 to 7 select 512 bytes up to 32 KB, and the bank address width grows from 7 bits to 13 bits. Code 0 means that no memory is fitted. With code 0 the enable bit has no effect and requests are left unclaimed. A line transfer runs as four longword beats at consecutive word addresses inside one aligned 16-byte line, with one acknowledge per beat.

The processor pulses `req` for one cycle to start a transfer. It then waits for `ack` once per beat. For a line write it changes `wdata` to the next beat's word in the cycle in which the current beat is acknowledged.

Top module: `lane_sram_ctrl`

## Requirements
- R1: A request is claimed only when `en` is 1 and `size_code` is not 000. Otherwise `ack` stays 0, `sram_cs_n` stays 1 and `sram_stb` stays 0000.
- R2: `sram_addr` equals `addr[14:2]` masked to its low 6+`size_code` bits (7 bits for code 001, up to 13 bits for code 111). All bits above that width are 0.
- R3: After reset, `sram_cs_n`=1, `sram_stb`=0 and `ack`=0. A `req` sampled high at a rising edge while idle starts a transfer. `sram_cs_n` is low from the next cycle. The strobes are high for exactly one cycle, in the second cycle. `ack` is high for one cycle, in the third cycle. `sram_cs_n` returns high after the last acknowledge.
- R4: Bit i of `sram_stb` serves data lane `[31-8i:24-8i]`, so bit 0 is the most significant byte. `xfer_sz` codes are 00 byte, 01 halfword, 10 longword and 11 line. A byte write raises only bit `addr[1:0]`. A halfword write raises bits 0 and 1 when `addr[1]`=0, and bits 2 and 3 when `addr[1]`=1. Longword and line writes raise all four bits.
- R5: On a byte write, `wdata[7:0]` appears on all four lanes of `sram_din`. On a halfword write, `wdata[15:0]` appears in both halves. A longword is passed through unchanged.
- R6: A read raises all four strobes. In the acknowledge cycle, `rdata` carries a byte from lane `addr[1:0]` in bits 7:0, or a halfword from the lane pair chosen by `addr[1]` in bits 15:0 (the lane with the lower strobe index in bits 15:8), zero-extended. A longword read returns the word as read.
- R7: A line transfer runs four beats. Their word addresses have the low two bits forced to 0, 1, 2 and 3 in turn, whatever the request's offset. The acknowledges come 3, 6, 9 and 12 cycles after acceptance. `sram_cs_n` stays low from acceptance through the fourth acknowledge.
- R8: In a line write, beat 0 takes `wdata` from the accepting cycle. Beat k+1 takes `wdata` from the cycle in which beat k is acknowledged.
- R9: `req` pulses while a transfer is in progress are ignored. Changes to `addr` or `wdata` after acceptance do not affect the transfer's address or its acknowledge count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Memory enable |
| size_code | input | 3 | Static array size code, 000 = no memory |
| req | input | 1 | One-cycle transfer start pulse |
| we | input | 1 | 1 = write, 0 = read |
| xfer_sz | input | 2 | Transfer size code |
| addr | input | 15 | Byte address inside the array |
| wdata | input | 32 | Write data |
| ack | output | 1 | Beat acknowledge |
| rdata | output | 32 | Steered read data, valid with `ack` |
| sram_cs_n | output | 1 | Bank chip select, active low |
| sram_we | output | 1 | Bank write enable |
| sram_addr | output | 13 | Shared bank word address |
| sram_din | output | 32 | Write data to the banks |
| sram_dout | input | 32 | Read data from the banks |
| sram_stb | output | 4 | Per-bank strobes, active on the rising edge |

## Verification
The hardest case to reach is the middle of a line write. There, the data for the next beat must be handed over in exactly the cycle in which the current beat is acknowledged, and the address must wrap inside the line from an unaligned start. The bench fills the whole 512-byte array with line writes, each starting at a different offset inside its line. It changes `wdata` only on the acknowledge it sees, so a slip of one cycle in the handover stores the wrong word and shows up in the full read-back. Ignored requests are provoked by pulsing `req` and changing `addr` during the setup and strobe cycles of a read.

// File: rtl/lane_sram_pkg.sv
`timescale 1ns/1ps
package lane_sram_pkg;

   // Transfer size codes seen on the request port
   typedef enum logic [1:0] {
      XS_BYTE = 2'd0,
      XS_HALF = 2'd1,
      XS_LONG = 2'd2,
      XS_LINE = 2'd3
   } xfer_sz_e;

   // Per-beat sequencer phases
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_STROBE = 2'd2,
      ST_REPLY  = 2'd3
   } seq_state_e;

endpackage

// File: rtl/lane_sram_seq.sv
`timescale 1ns/1ps
module lane_sram_seq
   import lane_sram_pkg::*;
#(
   parameter int BEATS = 4,
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              claim,
   input  logic              is_line,
   output seq_state_e        state_o,
   output logic [BEAT_W-1:0] beat_o,
   output logic              take_o,
   output logic              advance_o
);

   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

   if (BEATS < 2 || (1 << BEAT_W) != BEATS) begin : g_bad_beats
      $error("lane_sram_seq: BEATS must be a power of two of at least 2");
   end

   seq_state_e        state_q, state_d;
   logic [BEAT_W-1:0] beat_q, beat_d;

   always_comb begin
      state_d   = state_q;
      beat_d    = beat_q;
      take_o    = 1'b0;
      advance_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req && claim) begin
               state_d = ST_SETUP;
               beat_d  = '0;
               take_o  = 1'b1;
            end
         end
         ST_SETUP:  state_d = ST_STROBE;
         ST_STROBE: state_d = ST_REPLY;
         ST_REPLY: begin
            if (is_line && beat_q != LAST_BEAT) begin
               state_d   = ST_SETUP;
               beat_d    = beat_q + 1'b1;
               advance_o = 1'b1;
            end else begin
               state_d = ST_IDLE;
               beat_d  = '0;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         beat_q  <= beat_d;
      end
   end

   assign state_o = state_q;
   assign beat_o  = beat_q;

   // R7: a non-line transfer never leaves beat 0
   p_single_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && !is_line) |-> (beat_q == '0));

   // R7: inside a line, each reply that is not the last leads to the next beat's setup
   p_beat_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REPLY && is_line && beat_q != LAST_BEAT)
         |=> (state_q == ST_SETUP && beat_q == $past(beat_q) + 1'b1));

endmodule

// File: rtl/lane_sram_addr.sv
`timescale 1ns/1ps
module lane_sram_addr #(
   parameter int MAX_AW  = 13,
   parameter int AW_BASE = 6,
   parameter int SZ_W    = 3,
   parameter int BEAT_W  = 2
)
(
   input  logic [MAX_AW-1:0] word_i,
   input  logic [SZ_W-1:0]   size_code_i,
   input  logic              is_line_i,
   input  logic [BEAT_W-1:0] beat_i,
   output logic [MAX_AW-1:0] word_addr_o
);

   if (MAX_AW <= BEAT_W) begin : g_bad_width
      $error("lane_sram_addr: MAX_AW must exceed BEAT_W");
   end

   logic [MAX_AW-1:0] keep;
   logic [MAX_AW-1:0] seq_word;

   // Bit b survives when it lies below the width that the size code selects
   for (genvar b = 0; b < MAX_AW; b++) begin : g_keep
      assign keep[b] = (size_code_i != '0) && (b < AW_BASE + int'(size_code_i));
   end

   // Line beats stay inside their aligned line: the low bits follow the beat counter
   assign seq_word    = is_line_i ? {word_i[MAX_AW-1:BEAT_W], beat_i} : word_i;
   assign word_addr_o = seq_word & keep;

endmodule

// File: rtl/lane_sram_lanes.sv
`timescale 1ns/1ps
module lane_sram_lanes
   import lane_sram_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W     = LANES * LANE_W,
   localparam int OFF_W      = $clog2(LANES),
   localparam int HALF_LANES = LANES / 2
)
(
   input  xfer_sz_e          sz_i,
   input  logic              we_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] dout_i,
   output logic [LANES-1:0]  lane_en_o,
   output logic [DATA_W-1:0] din_o,
   output logic [DATA_W-1:0] rdata_o
);

   if (LANES < 2 || (1 << OFF_W) != LANES) begin : g_bad_lanes
      $error("lane_sram_lanes: LANES must be a power of two of at least 2");
   end

   logic [LANE_W-1:0] lane_rd [LANES];

   // Lane g is the g-th byte counting from the most significant end
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int               HI     = DATA_W - 1 - g * LANE_W;
      localparam int               H_POS  = g % HALF_LANES;
      localparam int               H_LO   = (HALF_LANES - 1 - H_POS) * LANE_W;
      localparam logic [OFF_W-1:0] G_OFF  = OFF_W'(g);
      localparam logic             G_HALF = 1'(g / HALF_LANES);

      assign lane_en_o[g] = !we_i ||
                            ((sz_i == XS_BYTE) ? (off_i == G_OFF) :
                             (sz_i == XS_HALF) ? (off_i[OFF_W-1] == G_HALF) : 1'b1);

      assign din_o[HI -: LANE_W] = (sz_i == XS_BYTE) ? wdata_i[LANE_W-1:0] :
                                   (sz_i == XS_HALF) ? wdata_i[H_LO +: LANE_W] :
                                                       wdata_i[HI -: LANE_W];

      assign lane_rd[g] = dout_i[HI -: LANE_W];
   end

   // Narrow reads are moved down to the least significant bits and zero-extended
   always_comb begin
      rdata_o = '0;
      unique case (sz_i)
         XS_BYTE: rdata_o[LANE_W-1:0] = lane_rd[off_i];
         XS_HALF: begin
            for (int k = 0; k < HALF_LANES; k++) begin
               rdata_o[(HALF_LANES - 1 - k) * LANE_W +: LANE_W] =
                  lane_rd[int'(off_i[OFF_W-1]) * HALF_LANES + k];
            end
         end
         default: rdata_o = dout_i;
      endcase
   end

endmodule

// File: rtl/lane_sram_ctrl.sv
`timescale 1ns/1ps
module lane_sram_ctrl
   import lane_sram_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int LANE_W    = 8,
   parameter int LINE_BITS = 128,
   parameter int MAX_AW    = 13,
   parameter int AW_BASE   = 6,
   parameter int SZ_W      = 3,
   localparam int DATA_W = LANES * LANE_W,
   localparam int OFF_W  = $clog2(LANES),
   localparam int BEATS  = LINE_BITS / DATA_W,
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
   localparam int ADDR_W = OFF_W + MAX_AW
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [SZ_W-1:0]   size_code,
   input  logic              req,
   input  logic              we,
   input  logic [1:0]        xfer_sz,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic              sram_cs_n,
   output logic              sram_we,
   output logic [MAX_AW-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_din,
   input  logic [DATA_W-1:0] sram_dout,
   output logic [LANES-1:0]  sram_stb
);

   if (LINE_BITS % DATA_W != 0) begin : g_bad_line
      $error("lane_sram_ctrl: LINE_BITS must be a multiple of the data width");
   end
   if (MAX_AW != AW_BASE + (1 << SZ_W) - 1) begin : g_bad_aw
      $error("lane_sram_ctrl: MAX_AW must match the widest size code");
   end

   // Request captured at acceptance
   logic              we_q;
   xfer_sz_e          sz_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wd_q;
   logic [DATA_W-1:0] rdata_q;

   seq_state_e        state;
   logic [BEAT_W-1:0] beat;
   logic              take, advance, claim, is_line;
   logic [LANES-1:0]  lane_en;
   logic [DATA_W-1:0] steered;

   assign claim   = en && (size_code != '0);
   assign is_line = (sz_q == XS_LINE);

   lane_sram_seq #(.BEATS(BEATS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .claim     (claim),
      .is_line   (is_line),
      .state_o   (state),
      .beat_o    (beat),
      .take_o    (take),
      .advance_o (advance)
   );

   lane_sram_addr #(
      .MAX_AW  (MAX_AW),
      .AW_BASE (AW_BASE),
      .SZ_W    (SZ_W),
      .BEAT_W  (BEAT_W)
   ) u_addr (
      .word_i      (addr_q[ADDR_W-1:OFF_W]),
      .size_code_i (size_code),
      .is_line_i   (is_line),
      .beat_i      (beat),
      .word_addr_o (sram_addr)
   );

   lane_sram_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
      .sz_i      (sz_q),
      .we_i      (we_q),
      .off_i     (addr_q[OFF_W-1:0]),
      .wdata_i   (wd_q),
      .dout_i    (sram_dout),
      .lane_en_o (lane_en),
      .din_o     (sram_din),
      .rdata_o   (steered)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b0;
         sz_q    <= XS_LONG;
         addr_q  <= '0;
         wd_q    <= '0;
         rdata_q <= '0;
      end else begin
         if (take) begin
            we_q   <= we;
            sz_q   <= xfer_sz_e'(xfer_sz);
            addr_q <= addr;
         end
         if (take || advance) begin
            wd_q <= wdata;
         end
         if (state == ST_STROBE) begin
            rdata_q <= steered;
         end
      end
   end

   assign sram_cs_n = (state == ST_IDLE);
   assign sram_we   = we_q && (state != ST_IDLE);
   assign sram_stb  = (state == ST_STROBE) ? lane_en : '0;
   assign ack       = (state == ST_REPLY);
   assign rdata     = rdata_q;

   // R1: an unclaimable request leaves the banks deselected
   p_absent_stays_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_cs_n && !claim) |=> sram_cs_n);

   // R2: no address bit above the selected width is ever driven
   p_addr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_cs_n) |-> ((sram_addr >> (AW_BASE + int'(size_code))) == '0));

   // R3: strobes only with chip select, for one cycle, and ack right after
   p_stb_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|sram_stb) |-> !sram_cs_n);
   p_stb_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|sram_stb) |=> (sram_stb == '0));
   p_ack_after_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(|sram_stb));

   // R4: a byte write touches exactly one bank
   p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((|sram_stb) && sram_we && sz_q == XS_BYTE) |-> $onehot(sram_stb));

   // R6: reads strobe every bank
   p_read_all_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|sram_stb) && !sram_we) |-> (&sram_stb));

endmodule

// File: tb/lane_sram_ctrl_bench.sv
`timescale 1ns/1ps
module lane_sram_ctrl_bench;

   localparam int LANES = 4;
   localparam int WORDS = 128;

   logic        clk, rst_n, en, req, we, ack, sram_cs_n, sram_we;
   logic [2:0]  size_code;
   logic [1:0]  xfer_sz;
   logic [14:0] addr;
   logic [31:0] wdata, rdata, sram_din, sram_dout;
   logic [12:0] sram_addr;
   logic [3:0]  sram_stb;

   lane_sram_ctrl u_lane_sram_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .size_code (size_code),
      .req       (req),
      .we        (we),
      .xfer_sz   (xfer_sz),
      .addr      (addr),
      .wdata     (wdata),
      .ack       (ack),
      .rdata     (rdata),
      .sram_cs_n (sram_cs_n),
      .sram_we   (sram_we),
      .sram_addr (sram_addr),
      .sram_din  (sram_din),
      .sram_dout (sram_dout),
      .sram_stb  (sram_stb)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   // Behavioural banks: each acts on the rising edge of its own strobe
   logic [7:0] bank [LANES][WORDS];
   logic [7:0] dout_l [LANES];
   logic [3:0] stb_prev = 4'b0;
   assign sram_dout = {dout_l[0], dout_l[1], dout_l[2], dout_l[3]};

   always @(sram_stb) begin
      for (int i = 0; i < LANES; i++) begin
         if (sram_stb[i] === 1'b1 && stb_prev[i] !== 1'b1 && sram_cs_n === 1'b0) begin
            if (sram_we) bank[i][sram_addr[6:0]] = sram_din[31-8*i -: 8];
            dout_l[i] = bank[i][sram_addr[6:0]];
         end
      end
      stb_prev = sram_stb;
   end

   // Reference contents, lane 0 = most significant byte
   logic [7:0] refm [LANES][WORDS];

   int n_cmp = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Observation record of one transfer
   logic [31:0] wb [4];
   logic [31:0] rb [4];
   logic [3:0]  sb [4];
   logic [12:0] sa [4];
   logic [31:0] sd [4];
   int          ack_at [4];
   int          n_ack, n_stb;
   bit          cs_gap, cs_seen;

   task automatic xfer(input bit wr, input logic [1:0] sz, input logic [14:0] a, input bit noisy);
      int nb;
      nb = (sz == 2'd3) ? 4 : 1;
      n_ack = 0; n_stb = 0; cs_gap = 0; cs_seen = 0;
      @(negedge clk);
      req = 1'b1; we = wr; xfer_sz = sz; addr = a; wdata = wb[0];
      @(negedge clk);
      req = 1'b0;
      for (int c = 1; c <= 3 * nb + 2; c++) begin
         if (noisy && c <= 2) begin
            req  = 1'b1;
            addr = a ^ 15'h0154;
         end else begin
            req = 1'b0;
         end
         if (sram_stb !== 4'b0) begin
            if (n_stb < 4) begin
               sb[n_stb] = sram_stb; sa[n_stb] = sram_addr; sd[n_stb] = sram_din;
            end
            n_stb++;
         end
         if (ack === 1'b1) begin
            if (n_ack < 4) begin
               rb[n_ack] = rdata; ack_at[n_ack] = c;
            end
            n_ack++;
            if (n_ack < nb) wdata = wb[n_ack];
         end
         if (sram_cs_n === 1'b0) cs_seen = 1;
         if (c <= 3 * nb && sram_cs_n !== 1'b0) cs_gap = 1;
         @(negedge clk);
      end
      req = 1'b0;
   endtask

   task automatic check_timing(input string tag, input int nb);
      check(n_ack == nb, tag, 32'(n_ack), 32'(nb));
      check(n_stb == nb, tag, 32'(n_stb), 32'(nb));
      check(!cs_gap && sram_cs_n === 1'b1, tag, {31'b0, cs_gap}, 32'b0);
      for (int k = 0; k < nb && k < n_ack; k++)
         check(ack_at[k] == 3 * k + 3, tag, 32'(ack_at[k]), 32'(3 * k + 3));
   endtask

   function automatic logic [12:0] exp_addr(logic [14:0] a, int code, bit line, int k);
      logic [12:0] w;
      w = a[14:2];
      if (line) w = {w[12:2], 2'(k)};
      return w & 13'((1 << (6 + code)) - 1);
   endfunction

   function automatic logic [3:0] exp_stb(bit wr, logic [1:0] sz, logic [14:0] a);
      if (!wr) return 4'hF;
      if (sz == 2'd0) return 4'b0001 << a[1:0];
      if (sz == 2'd1) return a[1] ? 4'b1100 : 4'b0011;
      return 4'hF;
   endfunction

   function automatic logic [31:0] exp_din(logic [1:0] sz, logic [31:0] d);
      if (sz == 2'd0) return {4{d[7:0]}};
      if (sz == 2'd1) return {2{d[15:0]}};
      return d;
   endfunction

   function automatic logic [31:0] exp_rd(logic [1:0] sz, logic [14:0] a);
      int w;
      w = int'(a[8:2]);
      if (sz == 2'd0) return {24'h0, refm[a[1:0]][w]};
      if (sz == 2'd1) return {16'h0, refm[{a[1], 1'b0}][w], refm[{a[1], 1'b1}][w]};
      return {refm[0][w], refm[1][w], refm[2][w], refm[3][w]};
   endfunction

   task automatic ref_write(input logic [1:0] sz, input logic [14:0] a, input logic [31:0] d);
      int w;
      w = int'(a[8:2]);
      if (sz == 2'd0) refm[a[1:0]][w] = d[7:0];
      else if (sz == 2'd1) begin
         refm[{a[1], 1'b0}][w] = d[15:8];
         refm[{a[1], 1'b1}][w] = d[7:0];
      end else begin
         refm[0][w] = d[31:24]; refm[1][w] = d[23:16];
         refm[2][w] = d[15:8];  refm[3][w] = d[7:0];
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(4 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [14:0] a;
      rst_n = 1'b0; en = 1'b0; size_code = 3'd1; req = 1'b0; we = 1'b0;
      xfer_sz = 2'd2; addr = '0; wdata = '0;
      for (int k = 0; k < 4; k++) wb[k] = '0;
      repeat (3) @(negedge clk);
      // R3: reset state
      check(sram_cs_n === 1'b1, "R3 reset cs_n", {31'b0, sram_cs_n}, 32'd1);
      check(sram_stb === 4'b0, "R3 reset stb", {28'b0, sram_stb}, 32'd0);
      check(ack === 1'b0, "R3 reset ack", {31'b0, ack}, 32'd0);
      rst_n = 1'b1;

      // R1: enable low, then size code 000 with enable high
      xfer(1'b0, 2'd2, 15'h0010, 1'b0);
      check(n_ack == 0 && n_stb == 0 && !cs_seen, "R1 en low", 32'(n_ack + n_stb), 32'd0);
      en = 1'b1; size_code = 3'd0;
      xfer(1'b1, 2'd2, 15'h0020, 1'b0);
      check(n_ack == 0 && n_stb == 0 && !cs_seen, "R1 code 000 write", 32'(n_ack + n_stb), 32'd0);
      xfer(1'b0, 2'd3, 15'h0030, 1'b0);
      check(n_ack == 0 && n_stb == 0 && !cs_seen, "R1 code 000 line", 32'(n_ack + n_stb), 32'd0);
      size_code = 3'd1;

      // R7/R8: fill the array with line writes from unaligned starts
      for (int ln = 0; ln < WORDS / 4; ln++) begin
         a = 15'(ln * 16 + (ln % 4) * 4 + (ln % 3));
         for (int k = 0; k < 4; k++) begin
            int w;
            w = ln * 4 + k;
            wb[k] = {8'(w * 7 + 1), 8'(w ^ 8'h5A), 8'(w + 8'h33), 8'(~w)};
         end
         xfer(1'b1, 2'd3, a, 1'b0);
         check_timing("R7 line write timing", 4);
         for (int k = 0; k < 4; k++) begin
            check(sa[k] == exp_addr(a, 1, 1'b1, k), "R7 line beat addr", 32'(sa[k]), 32'(exp_addr(a, 1, 1'b1, k)));
            check(sd[k] == wb[k], "R8 line beat data", sd[k], wb[k]);
            check(sb[k] == 4'hF, "R4 line strobes", 32'(sb[k]), 32'hF);
            ref_write(2'd2, 15'(ln * 16 + k * 4), wb[k]);
         end
      end

      // R6/R2/R3: longword read-back of every word
      for (int w = 0; w < WORDS; w++) begin
         a = 15'(w * 4);
         xfer(1'b0, 2'd2, a, 1'b0);
         check_timing("R3 long read timing", 1);
         check(rb[0] == exp_rd(2'd2, a), "R6 long read", rb[0], exp_rd(2'd2, a));
         check(sb[0] == 4'hF, "R6 read strobes", 32'(sb[0]), 32'hF);
         check(sa[0] == exp_addr(a, 1, 1'b0, 0), "R2 word addr", 32'(sa[0]), 32'(exp_addr(a, 1, 1'b0, 0)));
      end

      // R4/R5/R6: byte writes on every lane, then byte and word reads
      for (int w = 0; w < WORDS; w += 5) begin
         for (int o = 0; o < 4; o++) begin
            a = 15'(w * 4 + o);
            wb[0] = 32'(w) * 32'h9E3779B1 + 32'(o * 97);
            xfer(1'b1, 2'd0, a, 1'b0);
            check(sb[0] == exp_stb(1'b1, 2'd0, a), "R4 byte strobe", 32'(sb[0]), 32'(exp_stb(1'b1, 2'd0, a)));
            check(sd[0] == exp_din(2'd0, wb[0]), "R5 byte replication", sd[0], exp_din(2'd0, wb[0]));
            ref_write(2'd0, a, wb[0]);
            xfer(1'b0, 2'd0, a, 1'b0);
            check(rb[0] == exp_rd(2'd0, a), "R6 byte read", rb[0], exp_rd(2'd0, a));
            xfer(1'b0, 2'd2, a, 1'b0);
            check(rb[0] == exp_rd(2'd2, a), "R4 word after byte write", rb[0], exp_rd(2'd2, a));
         end
      end

      // R4/R5/R6: halfword writes in both halves
      for (int w = 1; w < WORDS; w += 3) begin
         for (int h = 0; h < 2; h++) begin
            a = 15'(w * 4 + h * 2);
            wb[0] = 32'(w * 32'h01234567) ^ 32'(h * 32'h5A5A);
            xfer(1'b1, 2'd1, a, 1'b0);
            check(sb[0] == exp_stb(1'b1, 2'd1, a), "R4 half strobe", 32'(sb[0]), 32'(exp_stb(1'b1, 2'd1, a)));
            check(sd[0] == exp_din(2'd1, wb[0]), "R5 half replication", sd[0], exp_din(2'd1, wb[0]));
            ref_write(2'd1, a, wb[0]);
            xfer(1'b0, 2'd1, a, 1'b0);
            check(rb[0] == exp_rd(2'd1, a), "R6 half read", rb[0], exp_rd(2'd1, a));
            xfer(1'b0, 2'd2, a, 1'b0);
            check(rb[0] == exp_rd(2'd2, a), "R4 word after half write", rb[0], exp_rd(2'd2, a));
         end
      end

      // R7: line reads from unaligned starts
      for (int ln = 0; ln < WORDS / 4; ln += 3) begin
         a = 15'(ln * 16 + 12 - (ln % 4) * 4);
         xfer(1'b0, 2'd3, a, 1'b0);
         check_timing("R7 line read timing", 4);
         for (int k = 0; k < 4; k++) begin
            check(rb[k] == exp_rd(2'd2, 15'(ln * 16 + k * 4)), "R7 line read data", rb[k], exp_rd(2'd2, 15'(ln * 16 + k * 4)));
            check(sa[k] == exp_addr(a, 1, 1'b1, k), "R7 line read addr", 32'(sa[k]), 32'(exp_addr(a, 1, 1'b1, k)));
         end
      end

      // R2: address width for every size code
      for (int code = 1; code < 8; code++) begin
         size_code = 3'(code);
         xfer(1'b0, 2'd2, 15'h7FFC, 1'b0);
         check(sa[0] == exp_addr(15'h7FFC, code, 1'b0, 0), "R2 masked addr", 32'(sa[0]), 32'(exp_addr(15'h7FFC, code, 1'b0, 0)));
         xfer(1'b0, 2'd3, 15'h5556, 1'b0);
         check(sa[3] == exp_addr(15'h5556, code, 1'b1, 3), "R2 masked line addr", 32'(sa[3]), 32'(exp_addr(15'h5556, code, 1'b1, 3)));
      end
      size_code = 3'd1;

      // R9: extra requests and address changes during a transfer
      for (int w = 10; w < 14; w++) begin
         a = 15'(w * 4 + (w % 4));
         xfer(1'b0, 2'd0, a, 1'b1);
         check(n_ack == 1 && n_stb == 1, "R9 busy request ignored", 32'(n_ack), 32'd1);
         check(sa[0] == exp_addr(a, 1, 1'b0, 0), "R9 address held", 32'(sa[0]), 32'(exp_addr(a, 1, 1'b0, 0)));
         check(rb[0] == exp_rd(2'd0, a), "R9 data of accepted request", rb[0], exp_rd(2'd0, a));
      end

      summary();
      $finish;
   end

endmodule